// File: doc/BRIEF.md
# Leaf Minimum Reduction with Search-Radius Update

This block sits at the bottom level of a tree-search detector. It receives a buffer of complete candidate symbol vectors, each with its accumulated path metric, and picks the one with the smallest metric. The pick uses a pipelined pairwise compare-select tree rather than a full sort. The winner is then compared with the best candidate kept so far for the current received vector. A strictly smaller metric replaces the kept vector and metric, and the squared search radius shrinks to that metric. The radius output feeds back to the node expander so that it can prune the branches that follow.

A metric of all ones stands for infinity. Such an entry marks an empty or pruned slot and never wins over a stored result. A clear input starts a new received vector: it resets the kept state to infinity or empty, and it discards any buffers still inside the reduction tree. When the search is finished, a request input publishes the kept vector as the final decision, together with a flag that tells whether any finite candidate was ever accepted.

Top module: `leaf_min_radius`

## Requirements
- R1: When `leaf_vld_i` is sampled high on rising edge k, the result is visible at the state outputs after edge k+log2(N_LEAF). With metrics equal to `leaf_met_i[i*MW +: MW]` and vectors equal to `leaf_vec_i[i*VW +: VW]`, the winner is the entry with the smallest metric.
- R2: When several entries share the smallest metric, the one with the lowest index i wins.
- R3: If the winner's metric is strictly smaller than `best_met_o`, then `best_vec_o` takes the winner's vector, `best_met_o` and `radius_o` both take its metric, and `found_o` goes to 1.
- R4: If the winner's metric is equal to or larger than `best_met_o`, the kept vector, metric, radius and found flag stay unchanged.
- R5: A buffer whose entries all carry the infinity sentinel (all ones) leaves the kept state unchanged.
- R6: While `clr_i` is high at a rising edge, that edge sets `radius_o` and `best_met_o` to all ones, `best_vec_o` to zero and `found_o` to 0. Any buffer sampled before that edge that has not yet updated the state is discarded.
- R7: A high `done_i` at a rising edge makes `dec_vld_o` high for exactly one cycle after that edge. On the same edge, `dec_vec_o` takes the value `best_vec_o` held just before the edge.
- R8: After reset, the block holds the same state that a clear produces, and `dec_vld_o` is 0.
- R9: Buffers presented on consecutive cycles are all reduced, and they update the state in the order they were presented, one per cycle.
- R10: `radius_o` never increases, except through a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Start of a new received vector; clears the kept state and flushes the tree |
| leaf_vld_i | input | 1 | A leaf buffer is present on this cycle |
| leaf_met_i | input | N_LEAF*MW | Packed leaf metrics, entry i at [i*MW +: MW]; all ones means infinity |
| leaf_vec_i | input | N_LEAF*VW | Packed leaf symbol vectors, entry i at [i*VW +: VW] |
| done_i | input | 1 | Request to publish the decision |
| radius_o | output | MW | Current squared search radius |
| best_met_o | output | MW | Metric of the kept best vector |
| best_vec_o | output | VW | Kept best vector |
| found_o | output | 1 | A finite-metric leaf has been accepted since the last clear |
| dec_vld_o | output | 1 | One-cycle pulse that marks the published decision |
| dec_vec_o | output | VW | Published decision vector |

## Verification
A wrong compare-select cell, or a tie rule that favours the higher index, produces a wrong `best_vec_o` or `best_met_o` exactly log2(N_LEAF) edges after the buffer is sampled. A loose (non-strict) or broken update rule shows up at that same edge as a changed vector after an equal-metric buffer, or as a `radius_o` that moves upward. A pipeline valid bit that is dropped or held one cycle too long shows up as a missed update or a misordered one across back-to-back buffers. A flush that does not take effect shows up as a finite radius after a clear.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  // Metric ordering, written once so every stage uses the same rule.
  function automatic logic metric_lt(input logic [63:0] a, input logic [63:0] b);
    return a < b;
  endfunction

  // Decides whether the right-hand operand displaces the left-hand one.
  // Ties keep the left (lower index) operand.
  function automatic logic take_right(input logic [63:0] left_m, input logic [63:0] right_m);
    return metric_lt(right_m, left_m);
  endfunction

endpackage

// File: rtl/lmr_cmp_cell.sv
module lmr_cmp_cell #(
  parameter int MW = 16,
  parameter int VW = 12
) (
  input  logic [MW-1:0] lo_met_i,
  input  logic [VW-1:0] lo_vec_i,
  input  logic [MW-1:0] hi_met_i,
  input  logic [VW-1:0] hi_vec_i,
  output logic [MW-1:0] sel_met_o,
  output logic [VW-1:0] sel_vec_o
);
  import lmr_pkg::*;

  logic pick_hi;

  always_comb begin
    pick_hi   = take_right(64'(lo_met_i), 64'(hi_met_i));
    sel_met_o = pick_hi ? hi_met_i : lo_met_i;
    sel_vec_o = pick_hi ? hi_vec_i : lo_vec_i;
  end

  always_comb begin
    AST_SEL_IS_MIN: assert ((sel_met_o <= lo_met_i) && (sel_met_o <= hi_met_i)); // R1
    if (lo_met_i == hi_met_i)
      AST_TIE_KEEPS_LOW: assert (sel_vec_o == lo_vec_i); // R2
  end

endmodule

// File: rtl/lmr_reduce_tree.sv
module lmr_reduce_tree #(
  parameter int N_LEAF = 8,
  parameter int MW     = 16,
  parameter int VW     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic                 in_vld_i,
  input  logic [N_LEAF*MW-1:0] in_met_i,
  input  logic [N_LEAF*VW-1:0] in_vec_i,
  output logic                 win_vld_o,
  output logic [MW-1:0]        win_met_o,
  output logic [VW-1:0]        win_vec_o
);
  localparam int LVLS = $clog2(N_LEAF);

  for (genvar s = 0; s < LVLS; s++) begin : g_stg
    localparam int OUTS = N_LEAF >> (s + 1);

    logic [MW-1:0] src_met [2*OUTS];
    logic [VW-1:0] src_vec [2*OUTS];
    logic          src_vld;
    logic [MW-1:0] q_met   [OUTS];
    logic [VW-1:0] q_vec   [OUTS];
    logic          q_vld;

    if (s == 0) begin : g_src_in
      for (genvar i = 0; i < 2*OUTS; i++) begin : g_unpack
        assign src_met[i] = in_met_i[i*MW +: MW];
        assign src_vec[i] = in_vec_i[i*VW +: VW];
      end
      assign src_vld = in_vld_i;
    end else begin : g_src_prev
      for (genvar i = 0; i < 2*OUTS; i++) begin : g_link
        assign src_met[i] = g_stg[s-1].q_met[i];
        assign src_vec[i] = g_stg[s-1].q_vec[i];
      end
      assign src_vld = g_stg[s-1].q_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_vld <= 1'b0;
      else if (flush_i) q_vld <= 1'b0;
      else              q_vld <= src_vld;
    end

    for (genvar c = 0; c < OUTS; c++) begin : g_cell
      logic [MW-1:0] c_met;
      logic [VW-1:0] c_vec;

      lmr_cmp_cell #(.MW(MW), .VW(VW)) u_cell (
        .lo_met_i (src_met[2*c]),
        .lo_vec_i (src_vec[2*c]),
        .hi_met_i (src_met[2*c+1]),
        .hi_vec_i (src_vec[2*c+1]),
        .sel_met_o(c_met),
        .sel_vec_o(c_vec)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_met[c] <= '1;
          q_vec[c] <= '0;
        end else if (src_vld) begin
          q_met[c] <= c_met;
          q_vec[c] <= c_vec;
        end
      end
    end
  end

  assign win_vld_o = g_stg[LVLS-1].q_vld;
  assign win_met_o = g_stg[LVLS-1].q_met[0];
  assign win_vec_o = g_stg[LVLS-1].q_vec[0];

  AST_FLUSH_KILLS_STAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !g_stg[0].q_vld); // R6

endmodule

// File: rtl/lmr_best_state.sv
module lmr_best_state #(
  parameter int MW = 16,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          win_vld_i,
  input  logic [MW-1:0] win_met_i,
  input  logic [VW-1:0] win_vec_i,
  input  logic          done_i,
  output logic [MW-1:0] radius_o,
  output logic [MW-1:0] best_met_o,
  output logic [VW-1:0] best_vec_o,
  output logic          found_o,
  output logic          dec_vld_o,
  output logic [VW-1:0] dec_vec_o
);
  import lmr_pkg::*;

  localparam logic [MW-1:0] INF = {MW{1'b1}};

  logic [MW-1:0] radius_q, best_met_q;
  logic [VW-1:0] best_vec_q, dec_vec_q;
  logic          found_q, dec_vld_q;
  logic          improve_w;

  assign improve_w = win_vld_i && !clr_i && metric_lt(64'(win_met_i), 64'(best_met_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      radius_q   <= INF;
      best_met_q <= INF;
      best_vec_q <= '0;
      found_q    <= 1'b0;
    end else if (clr_i) begin
      radius_q   <= INF;
      best_met_q <= INF;
      best_vec_q <= '0;
      found_q    <= 1'b0;
    end else if (improve_w) begin
      radius_q   <= win_met_i;
      best_met_q <= win_met_i;
      best_vec_q <= win_vec_i;
      found_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld_q <= 1'b0;
      dec_vec_q <= '0;
    end else begin
      dec_vld_q <= done_i;
      if (done_i) dec_vec_q <= best_vec_q;
    end
  end

  assign radius_o   = radius_q;
  assign best_met_o = best_met_q;
  assign best_vec_o = best_vec_q;
  assign found_o    = found_q;
  assign dec_vld_o  = dec_vld_q;
  assign dec_vec_o  = dec_vec_q;

  AST_UPDATE_SETS_RADIUS: assert property (@(posedge clk) disable iff (!rst_n)
    improve_w |=> (radius_q == $past(win_met_i)) && found_q); // R3
  AST_NO_UPDATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!improve_w && !clr_i) |=> $stable(best_vec_q) && $stable(radius_q)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (radius_q == INF) && !found_q); // R6
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> dec_vld_q); // R7
  AST_RADIUS_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> radius_q <= $past(radius_q)); // R10
  AST_FOUND_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> radius_q != INF); // R5

endmodule

// File: rtl/leaf_min_radius.sv
module leaf_min_radius #(
  parameter int N_LEAF = 8,
  parameter int MW     = 16,
  parameter int VW     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 leaf_vld_i,
  input  logic [N_LEAF*MW-1:0] leaf_met_i,
  input  logic [N_LEAF*VW-1:0] leaf_vec_i,
  input  logic                 done_i,
  output logic [MW-1:0]        radius_o,
  output logic [MW-1:0]        best_met_o,
  output logic [VW-1:0]        best_vec_o,
  output logic                 found_o,
  output logic                 dec_vld_o,
  output logic [VW-1:0]        dec_vec_o
);
  logic          win_vld;
  logic [MW-1:0] win_met;
  logic [VW-1:0] win_vec;

  lmr_reduce_tree #(.N_LEAF(N_LEAF), .MW(MW), .VW(VW)) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (clr_i),
    .in_vld_i (leaf_vld_i),
    .in_met_i (leaf_met_i),
    .in_vec_i (leaf_vec_i),
    .win_vld_o(win_vld),
    .win_met_o(win_met),
    .win_vec_o(win_vec)
  );

  lmr_best_state #(.MW(MW), .VW(VW)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .win_vld_i (win_vld),
    .win_met_i (win_met),
    .win_vec_i (win_vec),
    .done_i    (done_i),
    .radius_o  (radius_o),
    .best_met_o(best_met_o),
    .best_vec_o(best_vec_o),
    .found_o   (found_o),
    .dec_vld_o (dec_vld_o),
    .dec_vec_o (dec_vec_o)
  );

  AST_RADIUS_EQ_BEST: assert property (@(posedge clk) disable iff (!rst_n)
    radius_o == best_met_o); // R3

endmodule

// File: tb/leaf_min_radius_tb.sv
module leaf_min_radius_tb;
  localparam int N  = 8;
  localparam int MW = 16;
  localparam int VW = 12;
  localparam int L  = $clog2(N);
  localparam logic [MW-1:0] INF = {MW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0, leaf_vld_i = 1'b0, done_i = 1'b0;
  logic [N*MW-1:0] leaf_met_i = '0;
  logic [N*VW-1:0] leaf_vec_i = '0;
  logic [MW-1:0] radius_o, best_met_o;
  logic [VW-1:0] best_vec_o, dec_vec_o;
  logic found_o, dec_vld_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [MW-1:0] m [N];
  logic [VW-1:0] v [N];
  logic [MW-1:0] e_met;
  logic [VW-1:0] e_vec;
  logic          e_found;

  always #5 clk = ~clk;

  leaf_min_radius #(.N_LEAF(N), .MW(MW), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .leaf_vld_i(leaf_vld_i),
    .leaf_met_i(leaf_met_i), .leaf_vec_i(leaf_vec_i), .done_i(done_i),
    .radius_o(radius_o), .best_met_o(best_met_o), .best_vec_o(best_vec_o),
    .found_o(found_o), .dec_vld_o(dec_vld_o), .dec_vec_o(dec_vec_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: scan from the top index downward; "<=" lets lower indices win ties.
  task automatic model_apply();
    logic [MW-1:0] bm;
    logic [VW-1:0] bv;
    bm = m[N-1];
    bv = v[N-1];
    for (int i = N-2; i >= 0; i--) if (m[i] <= bm) begin bm = m[i]; bv = v[i]; end
    if (bm < e_met) begin e_met = bm; e_vec = bv; e_found = 1'b1; end
  endtask

  task automatic model_clear();
    e_met = INF; e_vec = '0; e_found = 1'b0;
  endtask

  task automatic load_inputs();
    for (int i = 0; i < N; i++) begin
      leaf_met_i[i*MW +: MW] = m[i];
      leaf_vec_i[i*VW +: VW] = v[i];
    end
  endtask

  // Drives one buffer for one cycle; returns at the negedge after its sampling edge.
  task automatic send();
    @(negedge clk);
    load_inputs();
    leaf_vld_i = 1'b1;
    @(negedge clk);
    leaf_vld_i = 1'b0;
  endtask

  task automatic settle();
    repeat (L) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    chk({tag, " radius"}, 32'(radius_o), 32'(e_met));
    chk({tag, " metric"}, 32'(best_met_o), 32'(e_met));
    chk({tag, " vector"}, 32'(best_vec_o), 32'(e_vec));
    chk({tag, " found"}, 32'(found_o), 32'(e_found));
  endtask

  task automatic fill_inf();
    for (int i = 0; i < N; i++) begin m[i] = INF; v[i] = VW'(i + 1); end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    model_clear();
  endtask

  task automatic t_reset();
    model_clear();
    check_state("R8 reset");
    chk("R8 dec_vld", 32'(dec_vld_o), 32'd0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < N; i++) begin m[i] = MW'(500 - 37*i + (i%3)*90); v[i] = VW'(16'h100 + i); end
    m[5] = 16'd40;
    send();
    repeat (L-1) @(negedge clk);
    chk("R1 no early update", 32'(found_o), 32'd0);
    @(negedge clk);
    model_apply();
    check_state("R1 R3 first min");
    for (int i = 0; i < N; i++) begin m[i] = MW'(30 + 3*i); v[i] = VW'(16'h200 + i); end
    m[7] = 16'd12;
    send(); settle(); model_apply();
    check_state("R3 improve at last index");
  endtask

  task automatic t_tie();
    do_clear();
    for (int i = 0; i < N; i++) begin m[i] = 16'd900; v[i] = VW'(16'h300 + i); end
    m[2] = 16'd77; m[6] = 16'd77; m[4] = 16'd77;
    send(); settle(); model_apply();
    check_state("R2 tie lower index");
  endtask

  task automatic t_no_update();
    for (int i = 0; i < N; i++) begin m[i] = 16'd1000; v[i] = VW'(16'h400 + i); end
    m[1] = 16'd77;
    send(); settle(); model_apply();
    check_state("R4 equal metric keeps");
    m[1] = 16'd78;
    send(); settle(); model_apply();
    check_state("R4 worse metric keeps");
  endtask

  task automatic t_all_inf();
    fill_inf();
    send(); settle(); model_apply();
    check_state("R5 all sentinel kept");
    do_clear();
    fill_inf();
    send(); settle(); model_apply();
    check_state("R5 all sentinel after clear");
  endtask

  task automatic t_clear_flush();
    for (int i = 0; i < N; i++) begin m[i] = MW'(50 + i); v[i] = VW'(16'h500 + i); end
    send();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    model_clear();
    settle();
    check_state("R6 clear flushes in-flight");
  endtask

  task automatic t_back_to_back();
    logic [MW-1:0] b_met [3];
    logic [VW-1:0] b_vec [3];
    do_clear();
    b_met[0] = 16'd300; b_met[1] = 16'd350; b_met[2] = 16'd120;
    for (int k = 0; k < 3; k++) b_vec[k] = VW'(16'h600 + 16*k);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) begin m[i] = b_met[k] + MW'(i); v[i] = b_vec[k] + VW'(i); end
      load_inputs();
      leaf_vld_i = 1'b1;
      @(negedge clk);
    end
    leaf_vld_i = 1'b0;
    repeat (L-2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) begin m[i] = b_met[k] + MW'(i); v[i] = b_vec[k] + VW'(i); end
      model_apply();
      chk($sformatf("R9 R10 radius after buffer %0d", k), 32'(radius_o), 32'(e_met));
      chk($sformatf("R9 vector after buffer %0d", k), 32'(best_vec_o), 32'(e_vec));
      @(negedge clk);
    end
  endtask

  task automatic t_decision();
    @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    chk("R7 dec pulse", 32'(dec_vld_o), 32'd1);
    chk("R7 dec vector", 32'(dec_vec_o), 32'(e_vec));
    chk("R7 dec found", 32'(found_o), 32'(e_found));
    @(negedge clk);
    chk("R7 single pulse", 32'(dec_vld_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tie();
    t_no_update();
    t_all_inf();
    t_clear_flush();
    t_back_to_back();
    t_decision();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule